// File: doc/BRIEF.md
# Half-Duplex Burst Power Sequencer

This block sequences the power-enable lines of the transmit and receive sections of a half-duplex front end. It runs on the transmit sample clock. The transmit burst strobe and the receive burst strobe arrive asynchronously, so each one passes through a two-flop synchronizer before its edges are detected. When a transmit burst ends, the transmit section stays powered for a programmable number of clocks, which covers the pipeline latency of the last samples. Over the same stretch the interpolation filter is fed midscale samples to flush it.

The receive section is powered opposite to the transmit strobe by default. One control bit hands receive power to the dedicated receive strobe instead. Each path has its own fast power-down enable. While that enable is clear, the path is held powered whatever the strobes do. The control byte is written through a one-cycle write strobe in the clock domain.

Top module: `burst_power_seq`

## Requirements
- R1: After a registered falling edge of the transmit strobe, with fast power-down on and delay D in 1..31, `tx_pwr_en` stays high for D clock edges and goes low on edge D after the edge that registered the fall.
- R2: With delay D = 0, `tx_pwr_en` goes low on the first clock edge after the edge at which the synchronized fall is detected.
- R3: The control byte is laid out with bits [7:3] as the power-down delay, bit 2 as the receive source select (1 = receive strobe), bit 1 as the transmit fast power-down enable and bit 0 as the receive fast power-down enable. It is loaded on a clock edge where `cfg_wr_en` is high.
- R4: A registered rising edge of the transmit strobe drives `tx_pwr_en` high on the next edge. If a power-down count is running, the rise cancels it.
- R5: `flush_req` is high for exactly FLUSH_LEN (33) clock edges, starting on the edge that registers the transmit fall. A transmit rise clears it.
- R6: `flush_code` carries the midscale code while `flush_req` is high and is zero otherwise. Midscale is 1 followed by zeros when OFFSET_BINARY = 1, and zero in two's complement.
- R7: With source select 0 and receive fast power-down on, a transmit fall powers the receive path up and a transmit rise powers it down, each on the edge that registers the edge.
- R8: With source select 1 and receive fast power-down on, a receive strobe rise powers the receive path up and a receive strobe fall powers it down. Transmit strobe edges then leave `rx_pwr_en` unchanged.
- R9: While the transmit fast power-down enable is 0, `tx_pwr_en` is held high.
- R10: While the receive fast power-down enable is 0, `rx_pwr_en` is held high.
- R11: Reset leaves both paths powered and `flush_req` low, and loads the control byte 0xFB (delay 31, source select 0, both fast enables on).
- R12: A strobe change driven between two clock edges is registered as an edge on the third clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_burst | input | 1 | Asynchronous transmit burst strobe |
| rx_burst | input | 1 | Asynchronous receive burst strobe |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wr_data | input | 8 | Control byte value |
| tx_pwr_en | output | 1 | Transmit section power enable |
| rx_pwr_en | output | 1 | Receive section power enable |
| flush_req | output | 1 | Interpolation filter flush request |
| flush_code | output | DATA_W | Sample fed to the filter input |

## Verification
On every cycle, the assertions check what each registered strobe edge does to the power enables on the following edge: the zero-delay turn-off, the hold while a count runs, the reassertion on a rise, and the receive response under each source select. They also check the hold-high behaviour of a disabled path, the start of the flush window and the flush code value. The exact length of a long power-down count, the cancellation of a running count, the 33-cycle flush window and the three-edge synchronizer latency are spread over many cycles. Only the bench shows those, through its directed scenarios and through the reference model it compares on every clock under random strobe and control traffic.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int DLY_W = 5;
    localparam int CFG_W = 8;

    // Control byte: delay in [7:3], source select [2], tx fast [1], rx fast [0]
    typedef struct packed {
        logic [DLY_W-1:0] pd_delay;
        logic             rx_src_rxen;
        logic             tx_fast_pd;
        logic             rx_fast_pd;
    } bps_cfg_t;

    localparam bps_cfg_t CFG_RESET = '{pd_delay: 5'd31, rx_src_rxen: 1'b0,
                                       tx_fast_pd: 1'b1, rx_fast_pd: 1'b1};

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } bps_edge_t;

    typedef enum logic [1:0] {
        TX_ON    = 2'd0,
        TX_DRAIN = 2'd1,
        TX_OFF   = 2'd2
    } tx_state_e;

    function automatic logic [31:0] mid_code(input int width, input bit offset_bin);
        logic [31:0] v;
        v = '0;
        if (offset_bin) v[width-1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bps_sync.sv
module bps_sync
    import bps_pkg::*;
#(
    parameter int N = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    async_in,
    output bps_edge_t [N-1:0] edge_o
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic meta_q, stab_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        always_comb begin
            edge_o[g].level = stab_q;
            edge_o[g].rise  = stab_q & ~prev_q;
            edge_o[g].fall  = ~stab_q & prev_q;
        end
    end

endmodule

// File: rtl/bps_cfg_reg.sv
module bps_cfg_reg
    import bps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output bps_cfg_t         cfg_o
);

    bps_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= CFG_RESET;
        else if (wr_en) cfg_q <= bps_cfg_t'(wr_data);
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/bps_tx_ctrl.sv
module bps_tx_ctrl
    import bps_pkg::*;
#(
    parameter int FLUSH_LEN = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  bps_edge_t        tx_edge,
    input  logic             fast_pd,
    input  logic [DLY_W-1:0] delay,
    output logic             pwr_en,
    output logic             flush_req
);

    localparam int FC_W = $clog2(FLUSH_LEN + 1);

    tx_state_e        st_q;
    logic [DLY_W-1:0] cnt_q;
    logic [FC_W-1:0]  fcnt_q;

    // power-down delay sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TX_ON;
            cnt_q <= '0;
        end else if (!fast_pd || tx_edge.rise) begin
            st_q  <= TX_ON;
            cnt_q <= '0;
        end else if (tx_edge.fall) begin
            if (delay == '0) begin
                st_q <= TX_OFF;
            end else begin
                st_q  <= TX_DRAIN;
                cnt_q <= delay;
            end
        end else if (st_q == TX_DRAIN) begin
            if (cnt_q == DLY_W'(1)) begin
                st_q  <= TX_OFF;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // flush window
    always_ff @(posedge clk) begin
        if (rst || tx_edge.rise) fcnt_q <= '0;
        else if (tx_edge.fall)   fcnt_q <= FC_W'(FLUSH_LEN);
        else if (fcnt_q != '0)   fcnt_q <= fcnt_q - 1'b1;
    end

    assign pwr_en    = (st_q != TX_OFF);
    assign flush_req = (fcnt_q != '0);

endmodule

// File: rtl/bps_rx_ctrl.sv
module bps_rx_ctrl
    import bps_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bps_edge_t tx_edge,
    input  bps_edge_t rx_edge,
    input  logic      src_rxen,
    input  logic      fast_pd,
    output logic      pwr_en
);

    logic up_ev, down_ev, on_q;

    always_comb begin
        if (src_rxen) begin
            up_ev   = rx_edge.rise;
            down_ev = rx_edge.fall;
        end else begin
            up_ev   = tx_edge.fall;
            down_ev = tx_edge.rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !fast_pd) on_q <= 1'b1;
        else if (up_ev)      on_q <= 1'b1;
        else if (down_ev)    on_q <= 1'b0;
    end

    assign pwr_en = on_q;

endmodule

// File: rtl/burst_power_seq.sv
module burst_power_seq
    import bps_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter bit OFFSET_BINARY = 1'b1,
    parameter int FLUSH_LEN     = 33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_burst,
    input  logic              rx_burst,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_data,
    output logic              tx_pwr_en,
    output logic              rx_pwr_en,
    output logic              flush_req,
    output logic [DATA_W-1:0] flush_code
);

    localparam logic [31:0]       MID_FULL = mid_code(DATA_W, OFFSET_BINARY);
    localparam logic [DATA_W-1:0] MIDSCALE = MID_FULL[DATA_W-1:0];

    bps_edge_t [1:0] edges;
    bps_cfg_t        cfg_q;
    logic            tx_rise, tx_fall, rx_rise, rx_fall;

    bps_sync #(.N(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({rx_burst, tx_burst}),
        .edge_o   (edges)
    );

    assign tx_rise = edges[0].rise;
    assign tx_fall = edges[0].fall;
    assign rx_rise = edges[1].rise;
    assign rx_fall = edges[1].fall;

    bps_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg_q)
    );

    bps_tx_ctrl #(.FLUSH_LEN(FLUSH_LEN)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_edge   (edges[0]),
        .fast_pd   (cfg_q.tx_fast_pd),
        .delay     (cfg_q.pd_delay),
        .pwr_en    (tx_pwr_en),
        .flush_req (flush_req)
    );

    bps_rx_ctrl u_rx (
        .clk      (clk),
        .rst      (rst),
        .tx_edge  (edges[0]),
        .rx_edge  (edges[1]),
        .src_rxen (cfg_q.rx_src_rxen),
        .fast_pd  (cfg_q.rx_fast_pd),
        .pwr_en   (rx_pwr_en)
    );

    assign flush_code = flush_req ? MIDSCALE : '0;

endmodule

// File: rtl/bps_checker.sv
module bps_checker
    import bps_pkg::*;
#(
    parameter int DATA_W        = 12,
    parameter bit OFFSET_BINARY = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_rise,
    input logic              tx_fall,
    input logic              rx_rise,
    input logic              rx_fall,
    input bps_cfg_t          cfg_q,
    input logic              tx_pwr_en,
    input logic              rx_pwr_en,
    input logic              flush_req,
    input logic [DATA_W-1:0] flush_code
);

    localparam logic [31:0]       MF  = mid_code(DATA_W, OFFSET_BINARY);
    localparam logic [DATA_W-1:0] MID = MF[DATA_W-1:0];

    p_fall_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_fall && cfg_q.tx_fast_pd && cfg_q.pd_delay != '0) |=> tx_pwr_en);

    p_zero_delay_off_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_fall && cfg_q.tx_fast_pd && cfg_q.pd_delay == '0) |=> !tx_pwr_en);

    p_rise_on_r4: assert property (@(posedge clk) disable iff (rst)
        tx_rise |=> tx_pwr_en);

    p_flush_start_r5: assert property (@(posedge clk) disable iff (rst)
        tx_fall |=> flush_req);

    p_flush_code_r6: assert property (@(posedge clk) disable iff (rst)
        flush_code == (flush_req ? MID : '0));

    p_rx_from_tx_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.rx_src_rxen && cfg_q.rx_fast_pd && tx_fall) |=> rx_pwr_en);

    p_rx_off_by_tx_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.rx_src_rxen && cfg_q.rx_fast_pd && tx_rise) |=> !rx_pwr_en);

    p_rx_from_rxen_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rx_src_rxen && cfg_q.rx_fast_pd && rx_fall) |=> !rx_pwr_en);

    p_rx_on_by_rxen_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.rx_src_rxen && cfg_q.rx_fast_pd && rx_rise) |=> rx_pwr_en);

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.tx_fast_pd |=> tx_pwr_en);

    p_rx_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.rx_fast_pd |=> rx_pwr_en);

endmodule

bind burst_power_seq bps_checker #(
    .DATA_W        (DATA_W),
    .OFFSET_BINARY (OFFSET_BINARY)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_rise    (tx_rise),
    .tx_fall    (tx_fall),
    .rx_rise    (rx_rise),
    .rx_fall    (rx_fall),
    .cfg_q      (cfg_q),
    .tx_pwr_en  (tx_pwr_en),
    .rx_pwr_en  (rx_pwr_en),
    .flush_req  (flush_req),
    .flush_code (flush_code)
);

// File: tb/sim_burst_power_seq.sv
module sim_burst_power_seq;

    localparam int DW    = 12;
    localparam int FLUSH = 33;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_burst = 1'b0, rx_burst = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [7:0]    cfg_wr_data = 8'h00;
    logic          tx_pwr_en, rx_pwr_en, flush_req;
    logic [DW-1:0] flush_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    burst_power_seq #(.DATA_W(DW), .OFFSET_BINARY(1'b1), .FLUSH_LEN(FLUSH)) u0 (
        .clk(clk), .rst(rst), .tx_burst(tx_burst), .rx_burst(rx_burst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .tx_pwr_en(tx_pwr_en), .rx_pwr_en(rx_pwr_en),
        .flush_req(flush_req), .flush_code(flush_code)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int  tx_hist[$];
    int  rx_hist[$];
    int  m_cfg, m_tx, m_rx, m_remain, m_flush;
    localparam int MID = 1 << (DW - 1);

    always @(posedge clk) begin
        int t_rise, t_fall, r_rise, r_fall, dly, sel, tfast, rfast;
        if (rst) begin
            tx_hist = '{0, 0, 0};
            rx_hist = '{0, 0, 0};
            m_cfg = 8'hFB; m_tx = 1; m_rx = 1; m_remain = 0; m_flush = 0;
        end else begin
            t_rise = (tx_hist[1] == 1 && tx_hist[2] == 0);
            t_fall = (tx_hist[1] == 0 && tx_hist[2] == 1);
            r_rise = (rx_hist[1] == 1 && rx_hist[2] == 0);
            r_fall = (rx_hist[1] == 0 && rx_hist[2] == 1);
            dly   = m_cfg / 8;
            sel   = (m_cfg / 4) % 2;
            tfast = (m_cfg / 2) % 2;
            rfast = m_cfg % 2;
            if (t_rise)          m_flush = 0;
            else if (t_fall)     m_flush = FLUSH;
            else if (m_flush > 0) m_flush--;
            if (!tfast || t_rise) begin
                m_tx = 1; m_remain = 0;
            end else if (t_fall) begin
                if (dly == 0) m_tx = 0;
                else m_remain = dly;
            end else if (m_remain > 0) begin
                m_remain--;
                if (m_remain == 0) m_tx = 0;
            end
            if (!rfast) m_rx = 1;
            else if (sel == 0) begin
                if (t_fall) m_rx = 1; else if (t_rise) m_rx = 0;
            end else begin
                if (r_rise) m_rx = 1; else if (r_fall) m_rx = 0;
            end
            if (cfg_wr_en) m_cfg = cfg_wr_data;
            tx_hist.push_front(int'(tx_burst)); void'(tx_hist.pop_back());
            rx_hist.push_front(int'(rx_burst)); void'(rx_hist.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(tx_pwr_en == m_tx, "R1/R2 R4 R9 model tx_pwr_en", tx_pwr_en, m_tx);
            check(rx_pwr_en == m_rx, "R7 R8 R10 model rx_pwr_en", rx_pwr_en, m_rx);
            check(flush_req == (m_flush > 0), "R5 model flush_req", flush_req, m_flush > 0);
            check(int'(flush_code) == (m_flush > 0 ? MID : 0), "R6 model flush_code",
                  flush_code, m_flush > 0 ? MID : 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_wr_data = v;
        cfg_wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !finished) begin
                finished = 1;
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        adv(3);
        rst = 1'b0;
        // R11 reset state
        check(tx_pwr_en == 1'b1, "R11 reset tx_pwr_en", tx_pwr_en, 1);
        check(rx_pwr_en == 1'b1, "R11 reset rx_pwr_en", rx_pwr_en, 1);
        check(flush_req == 1'b0, "R11 reset flush_req", flush_req, 0);

        // R7, R12: tx rise powers rx down on third edge
        tx_burst = 1'b1;
        adv(2);
        check(rx_pwr_en == 1'b1, "R12 rx before sync latency", rx_pwr_en, 1);
        adv(1);
        check(rx_pwr_en == 1'b0, "R7 rx off after tx rise", rx_pwr_en, 0);
        adv(4);

        // R1, R11 default delay 31; R5, R6 flush window
        tx_burst = 1'b0;
        adv(3);
        check(flush_req == 1'b1, "R5 flush starts", flush_req, 1);
        check(flush_code == DW'(MID), "R6 midscale code", flush_code, MID);
        check(rx_pwr_en == 1'b1, "R7 rx on after tx fall", rx_pwr_en, 1);
        adv(30);
        check(tx_pwr_en == 1'b1, "R1 tx held during delay 31", tx_pwr_en, 1);
        adv(1);
        check(tx_pwr_en == 1'b0, "R1 R11 tx off after delay 31", tx_pwr_en, 0);
        adv(1);
        check(flush_req == 1'b1, "R5 flush last cycle", flush_req, 1);
        adv(1);
        check(flush_req == 1'b0, "R5 flush ends", flush_req, 0);
        check(flush_code == '0, "R6 code zero outside flush", flush_code, 0);

        // R2, R3: delay 0
        cfg_write(8'h03);
        tx_burst = 1'b1; adv(6);
        tx_burst = 1'b0;
        adv(2);
        check(tx_pwr_en == 1'b1, "R2 tx on at detection", tx_pwr_en, 1);
        adv(1);
        check(tx_pwr_en == 1'b0, "R2 tx off after zero delay", tx_pwr_en, 0);
        adv(40);

        // R4, R5: rise cancels a running count
        cfg_write(8'h53);
        tx_burst = 1'b1; adv(6);
        tx_burst = 1'b0; adv(5);
        tx_burst = 1'b1; adv(15);
        check(tx_pwr_en == 1'b1, "R4 count cancelled", tx_pwr_en, 1);
        check(flush_req == 1'b0, "R5 flush cleared by rise", flush_req, 0);

        // R8: receive strobe as source
        cfg_write(8'h57);
        rx_burst = 1'b1; adv(3);
        check(rx_pwr_en == 1'b1, "R8 rx on after rx rise", rx_pwr_en, 1);
        rx_burst = 1'b0; adv(2);
        check(rx_pwr_en == 1'b1, "R8 rx before fall registers", rx_pwr_en, 1);
        adv(1);
        check(rx_pwr_en == 1'b0, "R8 rx off after rx fall", rx_pwr_en, 0);
        tx_burst = 1'b0; adv(6);
        tx_burst = 1'b1; adv(6);
        check(rx_pwr_en == 1'b0, "R8 tx edges ignored", rx_pwr_en, 0);
        adv(4);

        // R9, R10: fast power-down disabled
        cfg_write(8'h50);
        adv(1);
        check(rx_pwr_en == 1'b1, "R10 rx held", rx_pwr_en, 1);
        tx_burst = 1'b0; adv(20);
        check(tx_pwr_en == 1'b1, "R9 tx held", tx_pwr_en, 1);
        check(rx_pwr_en == 1'b1, "R10 rx held after tx fall", rx_pwr_en, 1);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) tx_burst = ~tx_burst;
            if (lfsr[7:4] == 4'h1) rx_burst = ~rx_burst;
            if (lfsr[15:9] == 7'h05) begin
                cfg_wr_data = {lfsr[2:0], lfsr[10:6]};
                cfg_wr_en   = 1'b1;
            end else begin
                cfg_wr_en   = 1'b0;
            end
            adv(1);
        end
        cfg_wr_en = 1'b0;
        adv(2);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule